// File: doc/BRIEF.md
# Blanked Peak Limit and Averaging Sampler

This block watches a stream of digitized current-sense values, one per clock, while a PWM steering stage drives one of its output pulses. It serves two purposes. The first is a cycle-by-cycle peak limit. Once a fixed blanking interval after the start of a pulse has passed, any sample above a programmable threshold raises a terminate request. The steering stage uses that request to end the pulse at once. This is not a fault: nothing latches beyond the current pulse, and the next pulse starts normally.

The second purpose is an average of the on-time current, scaled by four, for use by a slow average-current loop. Samples are summed only inside the on-time window that follows blanking. When the pulse ends, the sum is divided by the number of samples taken and the result is published. It is a per-pulse result held between pulses, not a running mean. Once a pulse has ended, or has been cut by the peak limit, the sense input is treated as zero and has no effect.

Top module: `peak_avg_sense`

## Requirements
- R1: For the first BLANK_CYC clock cycles of a pulse, counted from the first cycle in which `pulse_on` is sampled high, the sense value neither raises `term_req` nor enters the average. With the default of 9 cycles at 8 ns, this gives 72 ns.
- R2: During an active pulse, after blanking, a sampled `sense` strictly greater than `limit` drives `term_req` high in the next cycle. A value equal to `limit` has no effect. The worst-case delay from a crossing at pulse start to the request is BLANK_CYC+1 cycles, which is 80 ns by default and so within 130 ns.
- R3: Once raised, `term_req` stays high for as long as `pulse_on` is high. It drops in the same cycle that `pulse_on` goes low. The next pulse is handled exactly like any other pulse.
- R4: A sample enters the average only when the pulse is on, blanking has ended, and no terminate has been raised in this pulse. The sample that caused the terminate is still counted. Sense values seen while `pulse_on` is low have no effect on any output.
- R5: Suppose `pulse_on` is sampled low at a clock edge after having been high. If at least one sample was taken, then in the following cycle `avg_out` equals floor(4 × sum / count) of that pulse's samples and `avg_vld` is high for exactly one cycle.
- R6: `avg_out` changes only in a cycle in which `avg_vld` is high, and otherwise holds its value.
- R7: A pulse that ends with no samples taken produces no `avg_vld` strobe and leaves `avg_out` unchanged.
- R8: When the scaled average exceeds 2^OW−1, `avg_out` saturates at 2^OW−1 rather than wrapping.
- R9: While `rst_n` is low, `term_req`, `avg_out` and `avg_vld` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense | input | SW | Sampled current-sense value, unsigned |
| pulse_on | input | 1 | High while the steering stage drives a pulse |
| limit | input | SW | Peak threshold, unsigned |
| term_req | output | 1 | Request to end the active pulse |
| avg_out | output | OW | Held four-times average of the last pulse |
| avg_vld | output | 1 | One-cycle strobe when `avg_out` is refreshed |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- no request in the first cycle of a pulse;
- a raised request persists while the pulse lasts;
- `avg_vld` is a single-cycle strobe that appears only just after a pulse has ended;
- `avg_out` never moves without that strobe.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs against a behavioural model on every clock. These scenarios cover:
- the exact cycle of the request and the strictness of the threshold;
- excluding blanked samples and post-terminate samples from the sum;
- the arithmetic of the average;
- saturation;
- holding the output after a pulse shorter than the blanking interval.

// File: rtl/peak_avg_sense.sv
module peak_avg_sense #(
  parameter int SW        = 10,
  parameter int OW        = 11,
  parameter int BLANK_CYC = 9,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sense,
  input  logic          pulse_on,
  input  logic [SW-1:0] limit,
  output logic          term_req,
  output logic [OW-1:0] avg_out,
  output logic          avg_vld
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int AW = SW + CW;
  localparam int QW = AW + 2;
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
  localparam logic [QW-1:0] OUT_MAX   = QW'({OW{1'b1}});

  logic [BW-1:0] bcnt;
  logic          term_q;
  logic          was_on;
  logic [AW-1:0] acc;
  logic [CW-1:0] nsamp;
  logic [QW-1:0] quot;
  logic [OW-1:0] scaled;

  wire window  = pulse_on && (bcnt == BLANK_END);
  wire over    = window && (sense > limit);
  wire take    = window && !term_q;
  wire publish = !pulse_on && was_on && (nsamp != '0);

  assign quot     = {acc, 2'b00} / ((nsamp == '0) ? QW'(1) : QW'(nsamp));
  assign scaled   = (quot > OUT_MAX) ? OUT_MAX[OW-1:0] : quot[OW-1:0];
  assign term_req = term_q & pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '0;
      term_q  <= 1'b0;
      was_on  <= 1'b0;
      acc     <= '0;
      nsamp   <= '0;
      avg_out <= '0;
      avg_vld <= 1'b0;
    end else begin
      if (!pulse_on)              bcnt <= '0;
      else if (bcnt != BLANK_END) bcnt <= bcnt + 1'b1;
      term_q <= pulse_on && (term_q || over);
      was_on <= pulse_on;
      if (!pulse_on) begin
        acc   <= '0;
        nsamp <= '0;
      end else if (take) begin
        acc   <= acc + AW'(sense);
        nsamp <= nsamp + 1'b1;
      end
      avg_vld <= publish;
      if (publish) avg_out <= scaled;
    end
  end

  // R1
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> !term_req);

  // R3
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> (term_req || !pulse_on));

  // R5
  strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld |-> (!$past(pulse_on) && $past(pulse_on, 2)));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_vld |=> !avg_vld);

  // R6
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_out != $past(avg_out)) |-> avg_vld);
endmodule

// File: tb/peak_avg_sense_tb.sv
module peak_avg_sense_tb;
  localparam int SW = 10, OW = 11, B = 9, CW = 12;
  localparam int MAXO = (1 << OW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] sense = '0;
  logic          pulse_on = 1'b0;
  logic [SW-1:0] limit = 10'd700;
  logic          term_req;
  logic [OW-1:0] avg_out;
  logic          avg_vld;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_sum = 0, m_n = 0, m_avg = 0;
  bit m_term = 0, m_was = 0, m_vld = 0;

  always #4 clk = ~clk;

  peak_avg_sense #(.SW(SW), .OW(OW), .BLANK_CYC(B), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sense(sense), .pulse_on(pulse_on), .limit(limit),
    .term_req(term_req), .avg_out(avg_out), .avg_vld(avg_vld));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic cyc(input bit p, input int s);
    int q;
    bit take, over;
    pulse_on = p;
    sense = SW'(s);
    @(posedge clk);
    take = p && m_cnt >= B && !m_term;
    over = p && m_cnt >= B && s > int'(limit);
    if (!p && m_was && m_n > 0) begin
      q = (4 * m_sum) / m_n;
      if (q > MAXO) q = MAXO;
      m_avg = q;
      m_vld = 1;
    end else m_vld = 0;
    if (take) begin m_sum += s; m_n++; end
    if (!p) begin m_sum = 0; m_n = 0; end
    m_term = p && (m_term || over);
    m_cnt = p ? ((m_cnt < B) ? m_cnt + 1 : m_cnt) : 0;
    m_was = p;
    @(negedge clk);
    chk(term_req === (m_term && p), "R2/R3 term_req", int'(term_req), int'(m_term && p));
    chk(avg_vld === m_vld, "R5/R7 avg_vld", int'(avg_vld), int'(m_vld));
    chk(int'(avg_out) == m_avg, "R5/R6/R8 avg_out", int'(avg_out), m_avg);
  endtask

  task automatic flat(input int len, input int s);
    for (int i = 0; i < len; i++) cyc(1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(term_req == 0 && avg_vld == 0, "R9 flags", int'(term_req) + int'(avg_vld), 0);
    chk(avg_out == 0, "R9 avg_out", int'(avg_out), 0);
    rst_n = 1'b1;
    cyc(0, 0); cyc(0, 0);

    // R5 flat pulse: 11 samples of 100 -> 400
    flat(20, 100);
    cyc(0, 0);
    chk(avg_vld == 1 && avg_out == 400, "R5 flat", int'(avg_out), 400);
    cyc(0, 0);
    chk(avg_vld == 0, "R5 single strobe", int'(avg_vld), 0);

    // R5 ramp: samples 90..290 step 10 -> 4*3990/21 = 760
    for (int i = 0; i < 30; i++) cyc(1, 10 * i);
    cyc(0, 0);
    chk(avg_out == 760, "R5 ramp", int'(avg_out), 760);
    cyc(0, 0);

    // R1 spikes inside blanking ignored, average from later samples only
    for (int i = 0; i < B; i++) begin
      cyc(1, 1000);
      chk(term_req == 0, "R1 blank", int'(term_req), 0);
    end
    flat(10, 50);
    cyc(0, 0);
    chk(avg_out == 200, "R1 blank avg", int'(avg_out), 200);
    cyc(0, 0);

    // R2 overcurrent after blanking; R4 later samples ignored
    flat(11, 100);
    cyc(1, 100);
    chk(term_req == 0, "R2 below", int'(term_req), 0);
    cyc(1, 900);
    chk(term_req == 1, "R2 crossing", int'(term_req), 1);
    flat(6, 50);
    chk(term_req == 1, "R3 sticky", int'(term_req), 1);
    cyc(0, 0);
    chk(term_req == 0, "R3 drop", int'(term_req), 0);
    chk(avg_out == 1200, "R4 cut avg", int'(avg_out), 1200);
    cyc(0, 0);

    // R7 pulse shorter than blanking: no strobe, value held
    flat(5, 300);
    cyc(0, 0);
    chk(avg_vld == 0 && avg_out == 1200, "R7 short", int'(avg_out), 1200);
    cyc(0, 0);

    // R4 high sense while idle has no effect
    for (int i = 0; i < 10; i++) cyc(0, 1023);
    chk(term_req == 0 && avg_out == 1200, "R4 idle", int'(avg_out), 1200);

    // R2 equal to limit is not over; R8 saturation 2800 -> 2047
    flat(15, 700);
    chk(term_req == 0, "R2 equal", int'(term_req), 0);
    cyc(0, 0);
    chk(avg_out == MAXO, "R8 saturate", int'(avg_out), MAXO);
    cyc(0, 0);

    // R3 not a fault: normal pulse after overcurrent, R8 600 -> 2047
    flat(15, 600);
    cyc(0, 0);
    chk(avg_out == MAXO, "R8 saturate 600", int'(avg_out), MAXO);
    flat(14, 250);
    cyc(0, 0);
    chk(avg_out == 1000, "R3 recovers", int'(avg_out), 1000);
    cyc(0, 0);

    summary();
    $finish;
  end
endmodule